// File: doc/BRIEF.md
# Dual-Channel Manchester Word Decoder

This block receives serial words in Manchester II code on two independent bus channels, A and B, and decodes each channel in its own decoder. Each channel line arrives as a pair of already-digitized levels, a positive leg and a negative leg. A line counts as driven when the two legs differ, and as idle when they are equal. The block samples the lines with its master clock at twelve samples per 1 µs bit period. It finds the three-bit-time sync field and records whether the sync was command/status or data type. It then recovers sixteen data bits and a parity bit, checking every mid-bit transition and the odd parity.

A word that passes every check goes into that channel's receive register, together with its sync type, and raises that channel's received flag. A host read strobe clears the flag again. A word that fails a check leaves the register alone and produces a one-clock pulse on the shared encoding-error output. A master reset clears both registers and all flags and returns both decoders to the hunt for sync.

Top module: `dual_manchester_rx`

## Requirements
- R1: While rst_n is low at a rising clock edge, both word outputs become 0x0000, both sync-type outputs become 0, and both received flags and enc_err go low.
- R2: A line sample is driven when pos and neg differ, with level equal to pos, and is idle when they are equal. A sync is a run of one driven level lasting 15 to 21 clocks, followed at once by the opposite driven level. A high-first sync is command/status type (cmd output 1) and a low-first sync is data type (cmd output 0).
- R3: After the 18-clock second half of the sync come sixteen data bits and one parity bit, each 12 clocks long. A one is sent high-then-low and a zero low-then-high. The first data bit lands in word bit 15 and the last in bit 0.
- R4: For a good word, the word output, the cmd output and the received flag take their new values on the third rising edge after the edge that first registers sample 9 (counting from 0) of the parity bit. A new word also sets the flag if it was clear.
- R5: The sixteen data bits plus the parity bit must hold an odd number of ones. On a mismatch the word is discarded and enc_err pulses, with the same timing as R4.
- R6: If a bit has no mid-bit transition, or if either of its two sample points (clocks 3 and 9 of the bit) sees an idle line, the word is discarded. This covers a word that stops short of 20 bit times. enc_err pulses on the third rising edge after the edge that registers sample 9 of that bit, and the register and flag keep their old values.
- R7: enc_err is high for exactly one clock per rejected word, and rejections on either channel drive it.
- R8: A high rd_a (or rd_b) at a rising edge clears that channel's received flag at that edge, and the word and cmd outputs stay as they were. If a good word completes on the same edge, the flag stays high and the new word is stored.
- R9: Traffic on one channel never changes the other channel's outputs, and words arriving on both channels at the same time are both decoded.
- R10: A run of a driven level shorter than 15 or longer than 21 clocks, followed by the opposite level, is not a sync. It produces no word, no flag and no error.
- R11: A sync whose first half lasts 15 or 21 clocks is accepted. Bit timing is counted from the level change in the middle of the sync.
- R12: A new good word overwrites a receive register whose flag is still set, and the flag stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master sampling clock, 12 clocks per bit |
| rst_n | input | 1 | Synchronous active-low master reset |
| a_pos | input | 1 | Channel A positive line leg |
| a_neg | input | 1 | Channel A negative line leg |
| b_pos | input | 1 | Channel B positive line leg |
| b_neg | input | 1 | Channel B negative line leg |
| rd_a | input | 1 | Host read of channel A register, clears its flag |
| rd_b | input | 1 | Host read of channel B register, clears its flag |
| word_a | output | 16 | Channel A received word |
| cmd_a | output | 1 | Channel A sync type, 1 = command/status |
| rcv_a | output | 1 | Channel A word-received flag |
| word_b | output | 16 | Channel B received word |
| cmd_b | output | 1 | Channel B sync type, 1 = command/status |
| rcv_b | output | 1 | Channel B word-received flag |
| enc_err | output | 1 | One-clock pulse per rejected word on either channel |

## Verification
A sample phase that is off by even one clock moves the sample points toward the bit edges. It then shows up as spurious enc_err pulses or as words shifted by one bit, at the next word completion, about 240 clocks after the sync. A run counter that is stale or saturates wrongly shows as a sync that is missed (no flag where one is due) or one that is accepted falsely, and the result appears when the word would have completed. Faults in the flag and hold logic show at the ports one clock after a read strobe or a completion edge. The same-edge read case is driven to the exact clock.

// File: rtl/mwd_pkg.sv
// Shared types for the dual-channel Manchester word decoder.
// Assumes: one decoder per channel, all logic in the master clock domain.
package mwd_pkg;
    // Decoder phase: hunting for sync, timing the sync tail, or sampling bits.
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_SYNC_TAIL = 2'd1,
        ST_DATA      = 2'd2
    } dec_state_t;
endpackage

// File: rtl/mwd_line_sync.sv
// Brings one channel's two line legs into the clock domain and classifies
// the sample as driven (legs differ, level = positive leg) or idle.
// Assumes: STAGES >= 2; legs are asynchronous to clk.
module mwd_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pos,
    input  logic neg,
    output logic lvl,
    output logic vld
);
    logic [STAGES-1:0] pos_sh;
    logic [STAGES-1:0] neg_sh;

    // Shift both legs through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_sh <= '0;
            neg_sh <= '0;
        end else begin
            pos_sh <= {pos_sh[STAGES-2:0], pos};
            neg_sh <= {neg_sh[STAGES-2:0], neg};
        end
    end

    assign lvl = pos_sh[STAGES-1];
    assign vld = pos_sh[STAGES-1] ^ neg_sh[STAGES-1];
endmodule

// File: rtl/mwd_word_decoder.sv
// Per-channel Manchester II word decoder. It finds a sync from the length of
// a driven-level run, times each bit from the level change in the middle of
// the sync, samples each bit at its quarter and three-quarter points, and
// checks the transitions and the odd parity. It emits one-clock done or err
// pulses with the word and its sync type.
// Assumes: SPB divisible by 4; words are separated by idle or by an opposite level.
module mwd_word_decoder
    import mwd_pkg::*;
#(
    parameter int SPB       = 12,
    parameter int DATA_BITS = 16,
    parameter int SYNC_TOL  = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lvl,
    input  logic                 vld,
    output logic                 done,
    output logic                 err,
    output logic [DATA_BITS-1:0] word,
    output logic                 cmd
);
    localparam int SYNC_HALF = (SPB * 3) / 2;
    localparam int SYNC_MIN  = SYNC_HALF - SYNC_TOL;
    localparam int SYNC_MAX  = SYNC_HALF + SYNC_TOL;
    localparam int RUN_W     = $clog2(SYNC_MAX + 2);
    localparam int PH_W      = $clog2(SPB);
    localparam int BIT_W     = $clog2(DATA_BITS + 1);
    localparam logic [RUN_W-1:0] RUN_SAT   = RUN_W'(SYNC_MAX + 1);
    localparam logic [RUN_W-1:0] RUN_MIN   = RUN_W'(SYNC_MIN);
    localparam logic [RUN_W-1:0] RUN_MAX   = RUN_W'(SYNC_MAX);
    localparam logic [RUN_W-1:0] TAIL_LAST = RUN_W'(SYNC_HALF - 1);
    localparam logic [PH_W-1:0]  PH_LAST   = PH_W'(SPB - 1);
    localparam logic [PH_W-1:0]  PH_Q1     = PH_W'(SPB / 4);
    localparam logic [PH_W-1:0]  PH_Q3     = PH_W'((SPB * 3) / 4);
    localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(DATA_BITS);

    logic                 prev_lvl;
    logic                 prev_vld;
    logic [RUN_W-1:0]     run_len;
    dec_state_t           state;
    logic [RUN_W-1:0]     tail_cnt;
    logic [PH_W-1:0]      phase;
    logic [BIT_W-1:0]     bitn;
    logic                 first_lvl;
    logic                 first_vld;
    logic [DATA_BITS-1:0] shreg;
    logic                 cmd_q;
    logic                 sync_hit;
    logic                 bit_bad;

    // Track how long the line has held one driven level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_lvl <= 1'b0;
            prev_vld <= 1'b0;
            run_len  <= '0;
        end else begin
            prev_lvl <= lvl;
            prev_vld <= vld;
            if (vld && prev_vld && (lvl == prev_lvl)) begin
                if (run_len != RUN_SAT) run_len <= run_len + 1'b1;
            end else begin
                run_len <= vld ? RUN_W'(1) : '0;
            end
        end
    end

    // A sync is a change between driven levels after a run of legal length.
    assign sync_hit = (state == ST_IDLE) && vld && prev_vld && (lvl != prev_lvl)
                      && (run_len >= RUN_MIN) && (run_len <= RUN_MAX);

    // A bit fails when a sample point is idle or the two halves are equal.
    assign bit_bad = !vld || !first_vld || (lvl == first_lvl);

    // Sequence the sync tail and the bit sampling, and decide the outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            tail_cnt  <= '0;
            phase     <= '0;
            bitn      <= '0;
            first_lvl <= 1'b0;
            first_vld <= 1'b0;
            shreg     <= '0;
            cmd_q     <= 1'b0;
            done      <= 1'b0;
            err       <= 1'b0;
            word      <= '0;
            cmd       <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (sync_hit) begin
                        state    <= ST_SYNC_TAIL;
                        tail_cnt <= RUN_W'(1);
                        cmd_q    <= prev_lvl;
                    end
                end
                ST_SYNC_TAIL: begin
                    if (tail_cnt == TAIL_LAST) begin
                        state <= ST_DATA;
                        phase <= '0;
                        bitn  <= '0;
                    end else begin
                        tail_cnt <= tail_cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
                    if (phase == PH_LAST) bitn <= bitn + 1'b1;
                    if (phase == PH_Q1) begin
                        first_lvl <= lvl;
                        first_vld <= vld;
                    end
                    if (phase == PH_Q3) begin
                        if (bit_bad) begin
                            err   <= 1'b1;
                            state <= ST_IDLE;
                        end else if (bitn == BIT_LAST) begin
                            if (^{shreg, first_lvl}) begin
                                done <= 1'b1;
                                word <= shreg;
                                cmd  <= cmd_q;
                            end else begin
                                err <= 1'b1;
                            end
                            state <= ST_IDLE;
                        end else begin
                            shreg <= {shreg[DATA_BITS-2:0], first_lvl};
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // A word never both completes and fails (R5).
    assert_one_outcome_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    // Entering the sync tail requires a run of legal length (R10).
    assert_sync_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SYNC_TAIL && $past(state) == ST_IDLE)
        |-> ($past(run_len) >= RUN_MIN && $past(run_len) <= RUN_MAX));

    // A word is delivered only from the parity bit (R3).
    assert_word_after_parity_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(state) == ST_DATA && $past(bitn) == BIT_LAST));
endmodule

// File: rtl/mwd_rx_holding.sv
// Receive register for one channel: it holds the last good word and its sync
// type, and a received flag that a host read clears.
// Assumes: done is a one-clock pulse; a completion on the same edge beats a read.
module mwd_rx_holding #(
    parameter int DATA_BITS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 done,
    input  logic [DATA_BITS-1:0] word_in,
    input  logic                 cmd_in,
    input  logic                 rd,
    output logic [DATA_BITS-1:0] data,
    output logic                 cmd,
    output logic                 flag
);
    // Capture completed words and manage the received flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data <= '0;
            cmd  <= 1'b0;
            flag <= 1'b0;
        end else begin
            if (rd) flag <= 1'b0;
            if (done) begin
                data <= word_in;
                cmd  <= cmd_in;
                flag <= 1'b1;
            end
        end
    end

    // A completion is stored and flagged on the next edge (R4, R12).
    assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (flag && data == $past(word_in) && cmd == $past(cmd_in)));

    // A read with no completion clears the flag (R8).
    assert_read_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !done) |=> !flag);

    // Without a completion the stored word does not change (R6).
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> ($stable(data) && $stable(cmd)));

    // The flag rises only because a word completed (R4).
    assert_flag_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(done));
endmodule

// File: rtl/dual_manchester_rx.sv
// Top of the two-channel Manchester II word receiver. Each channel has its
// own synchronizer, decoder and receive register; the rejections of both
// channels merge into one registered error pulse.
// Assumes: clk runs at SPB times the bit rate; rst_n is synchronous.
module dual_manchester_rx #(
    parameter int SPB       = 12,
    parameter int DATA_BITS = 16,
    parameter int SYNC_TOL  = 3,
    parameter int SYNC_STG  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 a_pos,
    input  logic                 a_neg,
    input  logic                 b_pos,
    input  logic                 b_neg,
    input  logic                 rd_a,
    input  logic                 rd_b,
    output logic [DATA_BITS-1:0] word_a,
    output logic                 cmd_a,
    output logic                 rcv_a,
    output logic [DATA_BITS-1:0] word_b,
    output logic                 cmd_b,
    output logic                 rcv_b,
    output logic                 enc_err
);
    localparam int NUM_CH = 2;

    logic [NUM_CH-1:0]    pos_v, neg_v, rd_v;
    logic [NUM_CH-1:0]    lvl_v, vld_v, done_v, err_v, dcmd_v, hcmd_v, flag_v;
    logic [DATA_BITS-1:0] dword_v [NUM_CH];
    logic [DATA_BITS-1:0] hword_v [NUM_CH];

    assign pos_v = {b_pos, a_pos};
    assign neg_v = {b_neg, a_neg};
    assign rd_v  = {rd_b, rd_a};

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        mwd_line_sync #(.STAGES(SYNC_STG)) u_sync (
            .clk(clk), .rst_n(rst_n), .pos(pos_v[ch]), .neg(neg_v[ch]),
            .lvl(lvl_v[ch]), .vld(vld_v[ch])
        );
        mwd_word_decoder #(.SPB(SPB), .DATA_BITS(DATA_BITS), .SYNC_TOL(SYNC_TOL)) u_dec (
            .clk(clk), .rst_n(rst_n), .lvl(lvl_v[ch]), .vld(vld_v[ch]),
            .done(done_v[ch]), .err(err_v[ch]), .word(dword_v[ch]), .cmd(dcmd_v[ch])
        );
        mwd_rx_holding #(.DATA_BITS(DATA_BITS)) u_hold (
            .clk(clk), .rst_n(rst_n), .done(done_v[ch]), .word_in(dword_v[ch]),
            .cmd_in(dcmd_v[ch]), .rd(rd_v[ch]), .data(hword_v[ch]),
            .cmd(hcmd_v[ch]), .flag(flag_v[ch])
        );
    end

    // Merge the per-channel rejection pulses into the shared error output.
    always_ff @(posedge clk) begin
        if (!rst_n) enc_err <= 1'b0;
        else        enc_err <= |err_v;
    end

    assign word_a = hword_v[0];
    assign cmd_a  = hcmd_v[0];
    assign rcv_a  = flag_v[0];
    assign word_b = hword_v[1];
    assign cmd_b  = hcmd_v[1];
    assign rcv_b  = flag_v[1];

    // The error output follows a decoder rejection by one clock (R7).
    assert_err_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enc_err) |-> $past(|err_v));
endmodule

// File: tb/dual_manchester_rx_bench.sv
// Bench: a per-channel queue of line samples drives the block. Each queued
// word schedules its expected result as an event at the clock where the
// requirements place it, and every clock the outputs are compared with the
// expected state.
module dual_manchester_rx_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        a_pos, a_neg, b_pos, b_neg, rd_a, rd_b;
    logic [15:0] word_a, word_b;
    logic        cmd_a, rcv_a, cmd_b, rcv_b, enc_err;

    always #10 clk = ~clk;

    dual_manchester_rx u_dual_manchester_rx (
        .clk(clk), .rst_n(rst_n), .a_pos(a_pos), .a_neg(a_neg), .b_pos(b_pos),
        .b_neg(b_neg), .rd_a(rd_a), .rd_b(rd_b), .word_a(word_a), .cmd_a(cmd_a),
        .rcv_a(rcv_a), .word_b(word_b), .cmd_b(cmd_b), .rcv_b(rcv_b), .enc_err(enc_err)
    );

    typedef struct {
        int          at;
        int          ch;
        int          kind;   // 0 good word, 1 rejection, 2 read clear
        logic [15:0] w;
        logic        c;
    } ev_t;

    localparam logic [1:0] HI = 2'b10, LO = 2'b01, IDLE = 2'b00;

    logic [1:0]  qa[$];
    logic [1:0]  qb[$];
    ev_t         evq[$];
    logic [15:0] ew [2];
    logic        ec [2];
    logic        er [2];
    logic        ee;
    int          cyc = 0;
    int          n_cmp = 0;
    int          n_bad = 0;
    int          wd = 0;
    string       req = "R1";

    task automatic cmp(input string what, input logic [17:0] act, input logic [17:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // One clock: apply due events, compare, then drive the next inputs.
    task automatic step(input bit ra, input bit rb);
        ev_t e;
        @(negedge clk);
        cyc++;
        ee = 1'b0;
        foreach (evq[i]) if (evq[i].at == cyc && evq[i].kind == 2) er[evq[i].ch] = 1'b0;
        foreach (evq[i]) begin
            if (evq[i].at == cyc && evq[i].kind == 0) begin
                ew[evq[i].ch] = evq[i].w;
                ec[evq[i].ch] = evq[i].c;
                er[evq[i].ch] = 1'b1;
            end
            if (evq[i].at == cyc && evq[i].kind == 1) ee = 1'b1;
        end
        for (int i = evq.size() - 1; i >= 0; i--) if (evq[i].at <= cyc) evq.delete(i);
        cmp("channel A word/cmd/flag", {word_a, cmd_a, rcv_a}, {ew[0], ec[0], er[0]});
        cmp("channel B word/cmd/flag", {word_b, cmd_b, rcv_b}, {ew[1], ec[1], er[1]});
        cmp("enc_err", {17'd0, enc_err}, {17'd0, ee});
        {a_pos, a_neg} = (qa.size() != 0) ? qa.pop_front() : IDLE;
        {b_pos, b_neg} = (qb.size() != 0) ? qb.pop_front() : IDLE;
        rd_a = ra;
        rd_b = rb;
        if (ra) begin e.at = cyc + 1; e.ch = 0; e.kind = 2; e.w = '0; e.c = 1'b0; evq.push_back(e); end
        if (rb) begin e.at = cyc + 1; e.ch = 1; e.kind = 2; e.w = '0; e.c = 1'b0; evq.push_back(e); end
    endtask

    function automatic void push_n(input int ch, input logic [1:0] s, input int n);
        for (int i = 0; i < n; i++) begin
            if (ch == 0) qa.push_back(s);
            else qb.push_back(s);
        end
    endfunction

    // Queue one word. mode 0 good, 1 no transition in bit k, 2 bad parity,
    // 3 line idle from bit k on. len1 is the first sync half in clocks.
    task automatic send(input int ch, input bit c, input logic [15:0] d, input int mode,
                        input int k, input int len1, output int t_ev);
        ev_t e;
        int  s    = cyc + ((ch == 0) ? qa.size() : qb.size()) + 1;
        int  base = s + len1 + 18;
        bit  p    = ~^d;
        bit  b;
        int  fail_bit = -1;
        push_n(ch, c ? HI : LO, len1);
        push_n(ch, c ? LO : HI, 18);
        for (int i = 0; i < 17; i++) begin
            b = (i < 16) ? d[15 - i] : p;
            if (mode == 2 && i == 16) b = ~p;
            if (mode == 3 && i == k) begin fail_bit = k; break; end
            if (mode == 1 && i == k) begin push_n(ch, b ? HI : LO, 12); fail_bit = k; break; end
            push_n(ch, b ? HI : LO, 6);
            push_n(ch, b ? LO : HI, 6);
        end
        push_n(ch, IDLE, 40);
        if (mode == 2) fail_bit = 16;
        e.ch = ch; e.w = d; e.c = c;
        t_ev = 0;
        if (len1 >= 15 && len1 <= 21) begin
            if (fail_bit >= 0) begin e.kind = 1; e.at = base + 12 * fail_bit + 9 + 4; end
            else begin e.kind = 0; e.at = base + 12 * 16 + 9 + 4; end
            t_ev = e.at;
            evq.push_back(e);
        end
    endtask

    task automatic drain();
        while (qa.size() != 0 || qb.size() != 0) step(0, 0);
        repeat (8) step(0, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        wd++;
        if (wd > 200000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog %s: actual cycle %0d expected below 200000", req, wd);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int t;
        ew[0] = '0; ew[1] = '0; ec[0] = 0; ec[1] = 0; er[0] = 0; er[1] = 0; ee = 0;
        rst_n = 1'b0; rd_a = 0; rd_b = 0;
        {a_pos, a_neg} = IDLE; {b_pos, b_neg} = IDLE;
        // R1: reset state
        req = "R1";
        repeat (3) step(0, 0);
        rst_n = 1'b1;
        repeat (4) step(0, 0);

        // R3/R4: command word on A, MSB first, latency
        req = "R3";
        send(0, 1, 16'hA5C3, 0, 0, 18, t);
        drain();
        // R8: read clears flag, word kept
        req = "R8";
        step(1, 0);
        repeat (3) step(0, 0);
        // R2: data-type sync on B, single MSB set
        req = "R2";
        send(1, 0, 16'h8000, 0, 0, 18, t);
        drain();
        // R9: simultaneous words on both channels
        req = "R9";
        send(0, 1, 16'h7FFE, 0, 0, 18, t);
        send(1, 0, 16'h3C5A, 0, 0, 18, t);
        drain();
        // R12: overwrite while flag still set
        req = "R12";
        send(0, 0, 16'h0001, 0, 0, 18, t);
        drain();
        // R5: parity error on B
        req = "R5";
        send(1, 1, 16'hFFFF, 2, 0, 18, t);
        drain();
        // R6: missing mid-bit transition on A, short word on B
        req = "R6";
        send(0, 1, 16'h1357, 1, 5, 18, t);
        drain();
        send(1, 0, 16'hBEEF, 3, 10, 18, t);
        drain();
        // R7: rejections on both channels at once give one-clock pulses
        req = "R7";
        send(0, 0, 16'h4444, 1, 0, 18, t);
        send(1, 0, 16'h2222, 3, 0, 18, t);
        drain();
        // R10: runs of illegal length are not syncs (bit 15 zero keeps tail long)
        req = "R10";
        send(0, 1, 16'h1234, 0, 0, 24, t);
        drain();
        send(1, 1, 16'h1234, 0, 0, 12, t);
        drain();
        // R11: edge-of-tolerance syncs
        req = "R11";
        send(1, 1, 16'h6DB6, 0, 0, 15, t);
        drain();
        send(1, 0, 16'h9249, 0, 0, 21, t);
        drain();
        // R8: read on the same edge as a completion, the new word wins
        req = "R8";
        send(0, 1, 16'hCAFE, 0, 0, 18, t);
        while (cyc < t - 2) step(0, 0);
        step(1, 0);
        drain();
        step(1, 1);
        repeat (3) step(0, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule